// File: doc/BRIEF.md
# Pointer-Indexed Converter Register Bank

This block holds the control and result registers of a 12-bit data converter and exposes them to a host through a byte-wide transaction port. The port stands in for a serial bus transaction layer: every transaction begins with `txn_start_i`. In a write transaction the first byte loads a 2-bit register pointer. The next two bytes form a 16-bit word, high byte first. In a read transaction each request returns one byte of the register the pointer selects, high byte first. The pointer keeps its value from one transaction to the next.

Four registers sit behind the pointer: a read-only conversion result, a configuration word, and low and high threshold words. The block starts the converter model with a one-cycle `conv_start_o` pulse. It captures the result when `conv_done_i` arrives. It tracks whether a conversion is in flight and reports this in the status bit of the configuration word. Single-shot starts are requested by writing that status bit while the converter is powered down. In continuous mode the block restarts the converter by itself after every result.

Top module: `adc_regbank`

## Requirements
- R1: Pointer value 0 selects the conversion register, 1 the configuration, 2 the low threshold and 3 the high threshold. The pointer is loaded from bits 1:0 of the first write byte of a transaction. It keeps its value across later transactions, including read transactions.
- R2: A pointer byte with any of bits 7:2 set leaves the pointer unchanged.
- R3: Each `rd_req_i` cycle returns one byte on `rd_byte_o`, with `rd_valid_o` high, in the following cycle. The first read of a transaction returns bits 15:8 and the second returns bits 7:0. A write word takes effect when its second data byte is accepted.
- R4: After reset the four registers read 0000h, 8583h, 8000h and 7FF0h, in pointer order.
- R5: The conversion register holds the 12-bit result in bits 15:4, and bits 3:0 read 0. It changes only when a conversion finishes, and host writes to it are ignored.
- R6: A configuration write stores bits 14:0. When read, bit 15 is 0 while a conversion is in flight and 1 when the converter is idle.
- R7: A configuration write with bit 15 = 1 and bit 8 = 1, made while idle, raises `conv_start_o` for one cycle in the following cycle. The same write while busy starts nothing, and a write with bit 15 = 0 starts nothing.
- R8: While stored bit 8 is 0 (continuous mode) and the converter is idle, `conv_start_o` is raised in the following cycle. Each `conv_done_i` is therefore followed, one idle cycle later, by a new start.
- R9: Threshold writes store bits 15:4, and bits 3:0 of both thresholds read 0.
- R10: A `conv_done_i` pulse while no conversion is in flight leaves the conversion register unchanged.
- R11: `txn_start_i` restarts byte sequencing. A byte in the same cycle is taken as the pointer byte, and an unfinished word from an earlier transaction is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txn_start_i | input | 1 | Marks the start of a host transaction |
| wr_valid_i | input | 1 | Write byte valid |
| wr_byte_i | input | 8 | Write byte |
| rd_req_i | input | 1 | Request one read byte |
| rd_byte_o | output | 8 | Returned read byte |
| rd_valid_o | output | 1 | Read byte valid |
| conv_start_o | output | 1 | One-cycle conversion start request |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_data_i | input | 12 | Two's-complement conversion result |

## Verification
The assertions check the conversion handshake on every cycle. Each start pulse lasts one cycle and comes only from the idle state. The in-flight state holds until a done strobe arrives and then clears. A read request is always answered one cycle later. The pointer does not move without a valid pointer byte. Register contents, the status bit as the host sees it, reset values, ignored writes, stray done strobes and aborted transactions can only be shown by the bench's scenarios. These are compared against a behavioural model on every clock.

// File: rtl/adc_regbank_pkg.sv
package adc_regbank_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2;
  localparam int OS_BIT   = 15;
  localparam int MODE_BIT = 8;

  typedef enum logic [PTR_W-1:0] {
    REG_CONV = 2'd0,
    REG_CFG  = 2'd1,
    REG_LO   = 2'd2,
    REG_HI   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_PTR = 2'd0,
    PH_MSB = 2'd1,
    PH_LSB = 2'd2
  } wr_phase_e;

  localparam logic [DATA_W-1:0] CFG_RST = 16'h8583;
  localparam logic [DATA_W-1:0] LO_RST  = 16'h8000;
  localparam logic [DATA_W-1:0] HI_RST  = 16'h7FF0;
endpackage

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_word_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              rd_valid_o
);
  wr_phase_e         phase_q, phase_d, phase_eff;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] msb_q, msb_d;
  logic [BYTE_W-1:0] shadow_q, rd_byte_q;
  logic              hi_sent_q, rd_valid_q;

  assign phase_eff = txn_start_i ? PH_PTR : phase_q;

  always_comb begin
    ptr_d   = ptr_q;
    msb_d   = msb_q;
    phase_d = phase_eff;
    wr_en_o = 1'b0;
    if (wr_valid_i) begin
      unique case (phase_eff)
        PH_PTR: begin
          if (wr_byte_i[BYTE_W-1:PTR_W] == '0) ptr_d = wr_byte_i[PTR_W-1:0];
          phase_d = PH_MSB;
        end
        PH_MSB: begin
          msb_d   = wr_byte_i;
          phase_d = PH_LSB;
        end
        PH_LSB: begin
          wr_en_o = 1'b1;
          phase_d = PH_MSB;
        end
        default: phase_d = PH_PTR;
      endcase
    end
  end

  assign wr_word_o = {msb_q, wr_byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PTR;
      ptr_q   <= '0;
      msb_q   <= '0;
    end else begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
      msb_q   <= msb_d;
    end
  end

  // high byte read snapshots the low byte so the pair is coherent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_sent_q  <= 1'b0;
      shadow_q   <= '0;
      rd_byte_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req_i;
      if (rd_req_i) begin
        if (txn_start_i || !hi_sent_q) begin
          rd_byte_q <= rd_word_i[DATA_W-1:BYTE_W];
          shadow_q  <= rd_word_i[BYTE_W-1:0];
          hi_sent_q <= 1'b1;
        end else begin
          rd_byte_q <= shadow_q;
          hi_sent_q <= 1'b0;
        end
      end else if (txn_start_i) begin
        hi_sent_q <= 1'b0;
      end
    end
  end

  assign ptr_o      = ptr_q;
  assign rd_byte_o  = rd_byte_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_wr_i,
  input  logic wr_os_i,
  input  logic wr_single_i,
  input  logic cont_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o
);
  logic busy_q, start_q, start_req;

  // single-shot start only from power-down; continuous restarts whenever idle
  assign start_req = !busy_q && ((cfg_wr_i && wr_os_i && wr_single_i) || cont_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_req;
      if (start_req)   busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/adc_reg_file.sv
module adc_reg_file
  import adc_regbank_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_word_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [RES_W-1:0]  res_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              cfg_wr_o,
  output logic              cont_o
);
  localparam int PAD = DATA_W - RES_W;
  localparam logic [PTR_W-1:0] THR_BASE = REG_LO;

  logic [RES_W-1:0]  conv_q;
  logic [DATA_W-2:0] cfg_q;
  logic [RES_W-1:0]  thr_q [2];

  assign cfg_wr_o = wr_en_i && (ptr_i == REG_CFG);
  assign cont_o   = !cfg_q[MODE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              conv_q <= '0;
    else if (busy_i && done_i) conv_q <= res_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST[DATA_W-2:0];
    else if (cfg_wr_o) cfg_q <= wr_word_i[DATA_W-2:0];
  end

  for (genvar g = 0; g < 2; g++) begin : g_thr
    localparam logic [DATA_W-1:0] RST = (g == 0) ? LO_RST : HI_RST;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_q[g] <= RST[DATA_W-1:PAD];
      else if (wr_en_i && ptr_i == THR_BASE + PTR_W'(g))
        thr_q[g] <= wr_word_i[DATA_W-1:PAD];
    end
  end

  always_comb begin
    unique case (ptr_i)
      REG_CONV: rd_word_o = {conv_q, {PAD{1'b0}}};
      REG_CFG:  rd_word_o = {!busy_i, cfg_q};
      REG_LO:   rd_word_o = {thr_q[0], {PAD{1'b0}}};
      default:  rd_word_o = {thr_q[1], {PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
  import adc_regbank_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_req_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              rd_valid_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i
);
  logic [PTR_W-1:0]  ptr;
  logic              wr_en, cfg_wr, cont, busy;
  logic [DATA_W-1:0] wr_word, rd_word;

  adc_host_port i_host (
    .clk_i, .rst_ni, .txn_start_i, .wr_valid_i, .wr_byte_i, .rd_req_i,
    .rd_word_i (rd_word),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_word_o (wr_word),
    .rd_byte_o, .rd_valid_o
  );

  adc_reg_file #(.RES_W(RES_W)) i_regs (
    .clk_i, .rst_ni,
    .ptr_i     (ptr),
    .wr_en_i   (wr_en),
    .wr_word_i (wr_word),
    .busy_i    (busy),
    .done_i    (conv_done_i),
    .res_i     (conv_data_i),
    .rd_word_o (rd_word),
    .cfg_wr_o  (cfg_wr),
    .cont_o    (cont)
  );

  adc_conv_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .cfg_wr_i    (cfg_wr),
    .wr_os_i     (wr_word[OS_BIT]),
    .wr_single_i (wr_word[MODE_BIT]),
    .cont_i      (cont),
    .done_i      (conv_done_i),
    .start_o     (conv_start_o),
    .busy_o      (busy)
  );
endmodule

// File: rtl/adc_regbank_chk.sv
module adc_regbank_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       txn_start_i,
  input logic       wr_valid_i,
  input logic [7:0] wr_byte_i,
  input logic       rd_req_i,
  input logic       rd_valid_o,
  input logic       conv_start_o,
  input logic       conv_done_i,
  input logic       busy,
  input logic [1:0] ptr
);
  a_r7_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  a_r7_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !$past(busy));

  a_r6_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !conv_done_i) |=> busy);

  a_r8_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && conv_done_i) |=> !busy);

  a_r3_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);

  a_r2_reserved_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_i && wr_valid_i && wr_byte_i[7:2] != 6'd0) |=> $stable(ptr));

  a_r1_ptr_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(ptr));
endmodule

bind adc_regbank adc_regbank_chk i_adc_regbank_chk (
  .clk_i, .rst_ni, .txn_start_i, .wr_valid_i, .wr_byte_i, .rd_req_i,
  .rd_valid_o, .conv_start_o, .conv_done_i, .busy, .ptr
);

// File: tb/test_adc_regbank.sv
module test_adc_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_start_i = 1'b0, wr_valid_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0]  wr_byte_i = '0;
  logic        conv_done_i = 1'b0;
  logic [11:0] conv_data_i = '0;
  logic [7:0]  rd_byte_o;
  logic        rd_valid_o, conv_start_o;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  adc_regbank i_adc_regbank (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i, .wr_valid_i, .wr_byte_i,
    .rd_req_i, .rd_byte_o, .rd_valid_o, .conv_start_o, .conv_done_i, .conv_data_i
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // converter model: fixed latency, stepping sample values
  int          lat_cnt = 0;
  logic [11:0] sample = 12'hA5C;
  logic        inject = 1'b0;
  logic [11:0] inject_data = '0;
  int          n_starts = 0;

  always @(negedge clk) begin
    conv_done_i = 1'b0;
    if (inject) begin
      conv_done_i = 1'b1;
      conv_data_i = inject_data;
    end else if (conv_start_o) begin
      lat_cnt = 12;
    end else if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        conv_done_i = 1'b1;
        conv_data_i = sample;
        sample      = sample + 12'h1F3;
      end
    end
  end

  // behavioural reference model
  logic [15:0] m_conv, m_lo, m_hi, m_w, m_d;
  logic [14:0] m_cfg;
  logic [1:0]  m_ptr;
  logic [7:0]  m_msb, m_sh, m_rb;
  logic        m_rv, m_start, m_busy, m_commit;
  int          m_widx, m_rph, m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_conv = 16'h0000; m_cfg = 15'h0583; m_lo = 16'h8000; m_hi = 16'h7FF0;
      m_ptr = 0; m_msb = 0; m_sh = 0; m_rb = 0; m_rv = 0; m_start = 0; m_busy = 0;
      m_widx = 0; m_rph = 0;
    end else begin
      case (m_ptr)
        2'd0: m_w = m_conv;
        2'd1: m_w = {!m_busy, m_cfg};
        2'd2: m_w = m_lo;
        default: m_w = m_hi;
      endcase
      m_rv = rd_req_i;
      if (rd_req_i) begin
        if (txn_start_i || m_rph == 0) begin
          m_rb = m_w[15:8]; m_sh = m_w[7:0]; m_rph = 1;
        end else begin
          m_rb = m_sh; m_rph = 0;
        end
      end else if (txn_start_i) m_rph = 0;
      m_commit = 0;
      m_d = 0;
      m_idx = txn_start_i ? 0 : m_widx;
      if (wr_valid_i) begin
        if (m_idx == 0) begin
          if (wr_byte_i[7:2] == 0) m_ptr = wr_byte_i[1:0];
          m_widx = 1;
        end else if (m_idx == 1) begin
          m_msb = wr_byte_i; m_widx = 2;
        end else begin
          m_d = {m_msb, wr_byte_i}; m_commit = 1; m_widx = 1;
        end
      end else if (txn_start_i) m_widx = 0;
      m_start = !m_busy && ((m_commit && m_ptr == 2'd1 && m_d[15] && m_d[8]) || !m_cfg[8]);
      if (m_busy && conv_done_i) m_conv = {conv_data_i, 4'h0};
      if (m_start) m_busy = 1;
      else if (conv_done_i) m_busy = 0;
      if (m_commit) begin
        case (m_ptr)
          2'd1: m_cfg = m_d[14:0];
          2'd2: m_lo = {m_d[15:4], 4'h0};
          2'd3: m_hi = {m_d[15:4], 4'h0};
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison and read collection
  logic [15:0] got = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(conv_start_o === m_start, "R7 R8 start pulse", {15'd0, conv_start_o}, {15'd0, m_start});
      chk(rd_valid_o === m_rv, "R3 read valid", {15'd0, rd_valid_o}, {15'd0, m_rv});
      if (rd_valid_o) begin
        chk(rd_byte_o === m_rb, "R3 read byte", {8'd0, rd_byte_o}, {8'd0, m_rb});
        got = {got[7:0], rd_byte_o};
      end
      if (conv_start_o) n_starts++;
    end
  end

  task automatic wr_txn(input logic [7:0] p, input bit with_data, input logic [15:0] d);
    @(negedge clk); txn_start_i = 1; wr_valid_i = 1; wr_byte_i = p;
    @(negedge clk); txn_start_i = 0;
    if (!with_data) wr_valid_i = 0;
    else begin
      wr_byte_i = d[15:8];
      @(negedge clk); wr_byte_i = d[7:0];
      @(negedge clk); wr_valid_i = 0;
    end
  endtask

  task automatic rd_word(output logic [15:0] v);
    @(negedge clk); txn_start_i = 1; rd_req_i = 1;
    @(negedge clk); txn_start_i = 0;
    @(negedge clk); rd_req_i = 0;
    #1 v = got;
  endtask

  task automatic rd_at(input logic [1:0] p, input logic [15:0] exp, input string req);
    logic [15:0] v;
    wr_txn({6'd0, p}, 0, 16'h0);
    rd_word(v);
    chk(v === exp, req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset values, R1 pointer mapping
    rd_word(v); chk(v === 16'h0000, "R4 conv reset via default pointer R1", v, 16'h0000);
    rd_at(2'd1, 16'h8583, "R4 cfg reset");
    rd_at(2'd2, 16'h8000, "R4 low threshold reset");
    rd_at(2'd3, 16'h7FF0, "R4 high threshold reset");
    // R1 pointer persists across read transactions
    rd_word(v); chk(v === 16'h7FF0, "R1 pointer kept", v, 16'h7FF0);
    // R5 conversion register ignores writes
    wr_txn(8'h00, 1, 16'h1234);
    rd_word(v); chk(v === 16'h0000, "R5 conv write ignored", v, 16'h0000);
    // R9 thresholds store bits 15:4
    wr_txn(8'h02, 1, 16'hABCD);
    rd_word(v); chk(v === 16'hABC0, "R9 low threshold", v, 16'hABC0);
    wr_txn(8'h03, 1, 16'h1237);
    rd_word(v); chk(v === 16'h1230, "R9 high threshold", v, 16'h1230);
    // R2 reserved pointer bits: pointer stays at high threshold
    wr_txn(8'h05, 0, 16'h0);
    rd_word(v); chk(v === 16'h1230, "R2 reserved pointer byte ignored", v, 16'h1230);
    // R7 single-shot start; R6 status reads busy
    wr_txn(8'h01, 1, 16'hC5A3);
    rd_word(v); chk(v === 16'h45A3, "R6 OS reads busy", v, 16'h45A3);
    wr_txn(8'h01, 1, 16'hC5A3);   // R7 ignored while busy (start compared per clock)
    idle(20);
    rd_word(v); chk(v === 16'hC5A3, "R6 OS reads idle after done", v, 16'hC5A3);
    rd_at(2'd0, 16'hA5C0, "R5 result left-justified");
    // R7 OS=0 write starts nothing
    n_starts = 0;
    wr_txn(8'h01, 1, 16'h0583);
    idle(5);
    chk(n_starts == 0, "R7 no start on OS=0", 16'(n_starts), 16'd0);
    // R10 stray done while idle
    @(negedge clk); #1 inject_data = 12'h123; inject = 1;
    @(negedge clk); #1 inject = 0;
    rd_at(2'd0, 16'hA5C0, "R10 stray done ignored");
    // R11 aborted word discarded, same-cycle byte is pointer
    @(negedge clk); txn_start_i = 1; wr_valid_i = 1; wr_byte_i = 8'h02;
    @(negedge clk); txn_start_i = 0; wr_byte_i = 8'h55;
    @(negedge clk); txn_start_i = 1; wr_byte_i = 8'h02;
    @(negedge clk); txn_start_i = 0; wr_byte_i = 8'h66;
    @(negedge clk); wr_byte_i = 8'h10;
    @(negedge clk); wr_valid_i = 0;
    rd_word(v); chk(v === 16'h6610, "R11 restart sequencing", v, 16'h6610);
    // R8 continuous mode
    n_starts = 0;
    wr_txn(8'h01, 1, 16'h0483);
    idle(60);
    chk(n_starts >= 3, "R8 continuous restarts", 16'(n_starts), 16'd3);
    wr_txn(8'h01, 1, 16'h0583);
    idle(30);
    rd_word(v); chk(v === 16'h8583, "R8 stopped, R6 idle status", v, 16'h8583);
    rd_at(2'd0, m_conv, "R5 last continuous result");
    chk(m_conv[3:0] === 4'h0, "R5 low nibble zero", m_conv, {m_conv[15:4], 4'h0});
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule